// File: doc/BRIEF.md
# Dithered PWM Channel with Selectable Reload

This block drives one pulse-width-modulated output from a count clock. A basic period lasts 2^x clocks, where x is the synthesis parameter `CNT_W`. The width is set by a compare word of x+8 bits. Its upper x bits give the number of active clocks in every basic period. Its lower 8 bits add one extra active clock to a chosen subset of the 256 basic periods that make up a superframe. The subset is picked by comparing the bit-reversed period index with the fraction, so the extra clocks are spread evenly across the superframe.

Software writes the compare word into a holding register. The word takes effect only when it is copied into the active register. That copy happens at one of two points, chosen by a reload-mode input: once per superframe, which gives full x+8 bit accuracy, or once per basic period, which gives a faster response but lower effective resolution. The polarity input selects whether the active part of the pulse is high or low. It acts on the pin combinationally, whether or not the channel is enabled. While the channel is disabled, its counters rest at zero and the pin stays at the inactive level.

Top module: `dpwm_channel`

## Requirements
- R1: During and right after reset, the active and holding compare registers are zero, both counters are zero, and `pwm_out` equals the inverse of `act_high`.
- R2: `pwm_out` equals `act_high` in a clock where the pulse is active and `!act_high` otherwise. A change of `act_high` reaches `pwm_out` in the same clock, with no register in between.
- R3: While `enable` is low, the period and superframe counters are cleared at each edge and `pwm_out` equals `!act_high`, whatever the compare word.
- R4: A basic period is 2^CNT_W clocks. In the period with superframe index f (0..255), the first D clocks are active and the rest are inactive. D = cmp[CNT_W+7:8] + (rev8(f) < cmp[7:0] ? 1 : 0), where rev8 reverses the 8 bits of f.
- R5: With `sync_per_period` = 0, the active compare word changes only at the edge that wraps both counters back to index 0, or at the start of a run.
- R6: With `sync_per_period` = 1, the active compare word is reloaded at the edge that ends each basic period, and at no other running edge.
- R7: The first edge at which `enable` is sampled high starts a run. The first running clock has period and superframe index 0, and the compare word is loaded at that same edge.
- R8: A write strobed at the same edge as a reload is the value loaded. Between writes, the holding register keeps the last written value.
- R9: An active compare word of zero keeps `pwm_out` at `!act_high` in every clock.
- R10: Over one complete superframe with a constant compare word, the number of active clocks equals the compare word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM count clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_wr | input | 1 | Write strobe for the holding compare register |
| cmp_wdata | input | CNT_W+8 | Compare word to write |
| enable | input | 1 | Channel run enable |
| act_high | input | 1 | 1: active part of the pulse is high; 0: active part is low |
| sync_per_period | input | 1 | 0: reload once per superframe; 1: reload every basic period |
| pwm_out | output | 1 | Pulse output pin |

## Verification
The assertions assume that `enable`, `sync_per_period`, `cmp_wr` and `cmp_wdata` change only between clock edges, so that each edge sees one settled value of each. They also assume that the reload properties may read the sync value sampled at the previous edge as the mode of the reload that just happened. The stimulus changes every input one time unit after the falling edge. It toggles `act_high` alone in the middle of a clock to show that the pin responds at once. It drops and raises `enable` only on those same half-cycle boundaries, so that every run starts from a clean edge.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int DITH_W = 8;
    localparam int FRAMES = 1 << DITH_W;

    typedef logic [DITH_W-1:0] dith_t;

    typedef enum logic {
        RELOAD_FRAME  = 1'b0,
        RELOAD_PERIOD = 1'b1
    } reload_e;

    typedef struct packed {
        logic running;
        logic period_last;
        logic frame_last;
        logic start;
    } tick_t;

    function automatic dith_t bit_rev(input dith_t v);
        dith_t r;
        for (int i = 0; i < DITH_W; i++) begin
            r[i] = v[DITH_W-1-i];
        end
        return r;
    endfunction

    function automatic logic extra_clock(input dith_t frame_idx, input dith_t frac);
        return bit_rev(frame_idx) < frac;
    endfunction

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    output logic [CNT_W-1:0] sub_cnt,
    output dith_t            frame_cnt,
    output tick_t            tick
);

    localparam logic [CNT_W-1:0] SUB_MAX   = {CNT_W{1'b1}};
    localparam dith_t            FRAME_MAX = dith_t'(FRAMES - 1);

    logic             run_q;
    logic [CNT_W-1:0] sub_q;
    dith_t            frame_q;

    always_comb begin
        tick.running     = run_q;
        tick.start       = enable && !run_q;
        tick.period_last = enable && run_q && (sub_q == SUB_MAX);
        tick.frame_last  = tick.period_last && (frame_q == FRAME_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run_q   <= 1'b0;
            sub_q   <= '0;
            frame_q <= '0;
        end else if (!run_q) begin
            run_q   <= 1'b1;
            sub_q   <= '0;
            frame_q <= '0;
        end else begin
            sub_q <= sub_q + 1'b1;
            if (sub_q == SUB_MAX) begin
                frame_q <= frame_q + 1'b1;
            end
        end
    end

    assign sub_cnt   = sub_q;
    assign frame_cnt = frame_q;

endmodule

// File: rtl/dpwm_cmp_buf.sv
module dpwm_cmp_buf
    import dpwm_pkg::*;
#(
    parameter int CMP_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CMP_W-1:0] wdata,
    input  reload_e          mode,
    input  tick_t            tick,
    output logic [CMP_W-1:0] active_cmp
);

    logic [CMP_W-1:0] hold_q;
    logic [CMP_W-1:0] act_q;
    logic [CMP_W-1:0] hold_next;
    logic             load;

    always_comb begin
        hold_next = wr ? wdata : hold_q;
        unique case (mode)
            RELOAD_PERIOD: load = tick.start || tick.period_last;
            default:       load = tick.start || tick.frame_last;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            hold_q <= hold_next;
            if (load) begin
                act_q <= hold_next;
            end
        end
    end

    assign active_cmp = act_q;

endmodule

// File: rtl/dpwm_shaper.sv
module dpwm_shaper
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                    running,
    input  logic [CNT_W-1:0]        sub_cnt,
    input  dith_t                   frame_cnt,
    input  logic [CNT_W+DITH_W-1:0] active_cmp,
    input  logic                    act_high,
    output logic                    pwm_out
);

    localparam int CMP_W = CNT_W + DITH_W;

    logic [CNT_W:0] duty;
    logic           active;
    dith_t          frac;

    always_comb begin
        frac   = active_cmp[DITH_W-1:0];
        duty   = {1'b0, active_cmp[CMP_W-1:DITH_W]}
               + {{CNT_W{1'b0}}, extra_clock(frame_cnt, frac)};
        active = running && ({1'b0, sub_cnt} < duty);
        pwm_out = act_high ? active : !active;
    end

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
    import dpwm_pkg::*;
#(
    parameter  int CNT_W = 6,
    localparam int CMP_W = CNT_W + DITH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_wr,
    input  logic [CMP_W-1:0] cmp_wdata,
    input  logic             enable,
    input  logic             act_high,
    input  logic             sync_per_period,
    output logic             pwm_out
);

    tick_t            tick;
    logic [CNT_W-1:0] sub_w;
    dith_t            frm_w;
    logic [CMP_W-1:0] cmp_w;
    logic             run_w;
    reload_e          mode;

    assign mode  = sync_per_period ? RELOAD_PERIOD : RELOAD_FRAME;
    assign run_w = tick.running;

    dpwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .sub_cnt   (sub_w),
        .frame_cnt (frm_w),
        .tick      (tick)
    );

    dpwm_cmp_buf #(.CMP_W(CMP_W)) u_cmp_buf (
        .clk        (clk),
        .rst        (rst),
        .wr         (cmp_wr),
        .wdata      (cmp_wdata),
        .mode       (mode),
        .tick       (tick),
        .active_cmp (cmp_w)
    );

    dpwm_shaper #(.CNT_W(CNT_W)) u_shaper (
        .running    (run_w),
        .sub_cnt    (sub_w),
        .frame_cnt  (frm_w),
        .active_cmp (cmp_w),
        .act_high   (act_high),
        .pwm_out    (pwm_out)
    );

endmodule

// File: rtl/dpwm_channel_chk.sv
module dpwm_channel_chk #(
    parameter int CNT_W = 6,
    parameter int CMP_W = CNT_W + 8
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             act_high,
    input logic             sync_per_period,
    input logic             pwm_out,
    input logic             running,
    input logic [CNT_W-1:0] sub,
    input logic [7:0]       frm,
    input logic [CMP_W-1:0] cmp
);

    // R3: an idle channel shows only the inactive level
    p_idle_inactive_r3: assert property (@(posedge clk) disable iff (rst)
        !running |-> pwm_out == !act_high);

    // R3: dropping enable clears the run state and counter
    p_disable_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!running && sub == '0));

    // R9: zero width never produces an active clock
    p_zero_cmp_r9: assert property (@(posedge clk) disable iff (rst)
        cmp == '0 |-> pwm_out == !act_high);

    // R7: each run begins at index zero
    p_start_origin_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> (sub == '0 && frm == '0));

    // R4: the period counter advances by one per running clock
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> sub == CNT_W'($past(sub) + 1'b1));

    // R5: superframe mode reloads only when both counters wrap to zero
    p_frame_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && !$past(sync_per_period)
         && !(sub == '0 && frm == '0)) |-> $stable(cmp));

    // R6: no reload inside a basic period
    p_period_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && sub != '0) |-> $stable(cmp));

endmodule

bind dpwm_channel dpwm_channel_chk #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .enable          (enable),
    .act_high        (act_high),
    .sync_per_period (sync_per_period),
    .pwm_out         (pwm_out),
    .running         (run_w),
    .sub             (sub_w),
    .frm             (frm_w),
    .cmp             (cmp_w)
);

// File: tb/test_dpwm_channel.sv
`timescale 1ns/1ps
module test_dpwm_channel;

    localparam int X      = 4;
    localparam int CW     = X + 8;
    localparam int PER    = 1 << X;
    localparam int SUPER  = PER * 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmp_wr = 1'b0;
    logic [CW-1:0] cmp_wdata = '0;
    logic          enable = 1'b0;
    logic          act_high = 1'b1;
    logic          sync_per_period = 1'b0;
    logic          pwm_out;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    string tag = "R1";

    // behavioural reference state
    int m_run = 0, m_s = 0, m_f = 0, m_act = 0, m_hold = 0;

    always #2 clk = ~clk;

    dpwm_channel #(.CNT_W(X)) i_dpwm_channel (
        .clk             (clk),
        .rst             (rst),
        .cmp_wr          (cmp_wr),
        .cmp_wdata       (cmp_wdata),
        .enable          (enable),
        .act_high        (act_high),
        .sync_per_period (sync_per_period),
        .pwm_out         (pwm_out)
    );

    function automatic int rev8(int v);
        int r = 0;
        for (int i = 0; i < 8; i++) if ((v >> i) & 1) r += 1 << (7 - i);
        return r;
    endfunction

    function automatic bit model_out();
        int d;
        bit a;
        d = (m_act >> 8) + ((rev8(m_f) < (m_act % 256)) ? 1 : 0);
        a = (m_run != 0) && (m_s < d);
        return act_high ? a : !a;
    endfunction

    task automatic check(string t, bit got, bit exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: pwm_out=%0b expected %0b (cycle %0d)", t, got, exp, cyc);
        end
    endtask

    task automatic check_int(string t, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", t, got, exp);
        end
    endtask

    always @(posedge clk) begin
        int nh;
        cyc++;
        if (rst) begin
            m_run = 0; m_s = 0; m_f = 0; m_act = 0; m_hold = 0;
        end else begin
            nh = cmp_wr ? int'(cmp_wdata) : m_hold;
            if (!enable) begin
                m_run = 0; m_s = 0; m_f = 0;
            end else if (m_run == 0) begin
                m_run = 1; m_s = 0; m_f = 0; m_act = nh;
            end else begin
                m_s++;
                if (m_s == PER) begin
                    m_s = 0;
                    m_f = (m_f + 1) % 256;
                    if (sync_per_period || m_f == 0) m_act = nh;
                end
            end
            m_hold = nh;
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) check(tag, pwm_out, model_out());
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic write_cmp(int v);
        cmp_wr = 1'b1;
        cmp_wdata = CW'(v);
        step(1);
        cmp_wr = 1'b0;
    endtask

    task automatic count_active(int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out == act_high) c++;
        end
        #1;
    endtask

    initial begin
        int c;
        bit v;
        step(3);
        // R1: output inactive while reset holds
        check("R1", pwm_out, 1'b0);
        act_high = 1'b0;
        #1 check("R1", pwm_out, 1'b1);
        act_high = 1'b1;
        rst = 1'b0;
        step(1);
        cmp_on = 1'b1;
        check("R1", pwm_out, 1'b0);

        // R3: disabled channel ignores a stored width
        tag = "R3";
        write_cmp(12'h35A);
        step(40);
        act_high = 1'b0;
        step(10);
        check("R3", pwm_out, 1'b1);
        act_high = 1'b1;
        #1 check("R3", pwm_out, 1'b0);

        // R2: polarity flips inside the clock while running
        tag = "R2";
        enable = 1'b1;
        for (int k = 0; k < 6; k++) begin
            step(3 + 5 * k);
            v = pwm_out;
            act_high = !act_high;
            #1 check("R2", pwm_out, !v);
        end
        act_high = 1'b1;

        // R10 and R4: one full superframe from a fresh start
        tag = "R4";
        enable = 1'b0;
        step(2);
        enable = 1'b1;
        count_active(SUPER, c);
        check_int("R10", c, 12'h35A);

        // R5: a write mid-superframe waits for the wrap
        tag = "R5";
        step(700);
        write_cmp(12'h7FF);
        step(SUPER + 200);

        // R6: per-period reload
        tag = "R6";
        sync_per_period = 1'b1;
        for (int k = 0; k < 60; k++) begin
            write_cmp((k * 389 + 17) % (1 << CW));
            step(36);
        end

        // R8: writes at arbitrary cycles, including reload edges
        tag = "R8";
        for (int k = 0; k < 900; k++) begin
            if (($urandom % 3) == 0) sync_per_period = !sync_per_period;
            cmp_wr = 1'b1;
            cmp_wdata = CW'($urandom);
            step(1);
            cmp_wr = 1'b0;
            step(1 + ($urandom % 40));
        end

        // R7: restart alignment after disable
        tag = "R7";
        for (int k = 0; k < 25; k++) begin
            enable = 1'b0;
            step(1 + ($urandom % 5));
            if (k % 2 == 0) write_cmp($urandom % (1 << CW));
            enable = 1'b1;
            step(5 + ($urandom % 90));
        end

        // R9: zero width stays inactive for a whole superframe
        tag = "R9";
        sync_per_period = 1'b1;
        write_cmp(0);
        step(PER + 2);
        count_active(SUPER, c);
        check_int("R9", c, 0);

        cmp_on = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule